// File: doc/BRIEF.md
# Two-Group Rotating DMA Bus Arbiter

This block decides, every clock cycle, which requester owns a shared data bus: a host-port auxiliary requester, one of six DMA channels, or the CPU. The host requester always wins. Otherwise a DMA channel may take the bus, and the CPU gets whatever cycles are left. Each DMA channel carries a group bit that puts it in a high or a low priority group. A low-group channel is served only when no enabled high-group channel is asking for service. A channel asks for service only when it is not waiting for its sync event and still has transfers left.

Within each group, service rotates round-robin with one grant per element transfer. After a grant, the search in that group starts at the channel just past the one served, wrapping from the last channel to channel 0. The other group's search position does not move. Across all channels together, DMA grants are spaced at least `GAP` cycles apart (four by default), which limits the combined element rate. In the cycles between DMA grants a requesting CPU is given the bus.

All grants are registered. Requests sampled at one rising edge produce grants that are visible for the whole following cycle.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, all grant outputs are 0. After reset both group search positions point at channel 0, and a DMA grant is allowed immediately.
- R2: A channel whose `ch_en` bit is 0 is never granted, whatever its `ch_req` bit is.
- R3: In any cycle at most one of `host_gnt`, `cpu_gnt` and the bits of `ch_gnt` is 1, so `ch_gnt` is one-hot or zero.
- R4: When `host_req` is 1 at an edge, `host_gnt` is 1 in the following cycle, and no DMA or CPU grant is given in that cycle.
- R5: A channel with `ch_hi` = 0 (low group) is granted only when no channel with `ch_hi` = 1 (high group) has both `ch_req` and `ch_en` set.
- R6: Within a group, the channel granted is the first requesting member found by scanning upward from the group's search position, wrapping after channel NUM_CH-1. After a grant to channel c, that group's position becomes c+1 mod NUM_CH. The other group's position is unchanged.
- R7: Two DMA grants are always at least `GAP` cycles apart. When a DMA request is pending and the host is not requesting, a grant is given as soon as `GAP` cycles have passed since the previous one.
- R8: `cpu_gnt` is 1 exactly when the CPU requested and the cycle was given neither to the host nor to a DMA channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ch_req | input | NUM_CH | Per-channel element-transfer request (sync event seen, work left) |
| ch_en | input | NUM_CH | Per-channel enable; a 0 masks the request |
| ch_hi | input | NUM_CH | Per-channel group select: 1 high group, 0 low group |
| host_req | input | 1 | Host-port auxiliary bus request |
| cpu_req | input | 1 | CPU bus request |
| ch_gnt | output | NUM_CH | Registered one-hot DMA channel grant |
| host_gnt | output | 1 | Registered host-port grant |
| cpu_gnt | output | 1 | Registered CPU grant |

## Verification
A wrong search position in either group shows as the wrong channel index on `ch_gnt` at the very next grant that group issues. That is at most `GAP` cycles after the fault while requests are pending. A wrong spacing counter shows as a DMA grant one cycle early or late, or as a CPU grant in a cycle that belonged to a channel. Either one appears within one spacing window. A faulty owner decision shows in the same registered cycle as two grants at once, or as the host or high group being passed over. The bench compares every output bit against an independent model on every cycle, so each of these faults is caught in the first cycle it becomes visible.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_DMA  = 2'd2,
    OWN_CPU  = 2'd3
  } bus_owner_e;

  // index reached by stepping forward from base, wrapped into 0..n-1
  function automatic int unsigned wrap_idx(input int unsigned base,
                                           input int unsigned step,
                                           input int unsigned n);
    return (base + step) % n;
  endfunction

endpackage

// File: rtl/dma_rr_group.sv
module dma_rr_group #(
  parameter  int N  = 6,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] pick,
  output logic         any
);
  import dma_arb_pkg::*;

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] pick_idx;

  // first requester at or after the search position, wrapping
  always_comb begin
    pick     = '0;
    pick_idx = '0;
    any      = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!any && req[wrap_idx(32'(ptr_q), unsigned'(k), unsigned'(N))]) begin
        any      = 1'b1;
        pick[wrap_idx(32'(ptr_q), unsigned'(k), unsigned'(N))] = 1'b1;
        pick_idx = PW'(wrap_idx(32'(ptr_q), unsigned'(k), unsigned'(N)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (adv && any) begin
      ptr_q <= PW'(wrap_idx(32'(pick_idx), 1, unsigned'(N)));
    end
  end

endmodule

// File: rtl/dma_gap_timer.sv
module dma_gap_timer #(
  parameter  int GAP = 4,
  localparam int CW  = $clog2(GAP + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic ready
);
  logic [CW-1:0] cnt_q;

  assign ready = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (fire) begin
      cnt_q <= CW'(GAP - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int NUM_CH = 6,
  parameter int GAP    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ch_req,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_hi,
  input  logic              host_req,
  input  logic              cpu_req,
  output logic [NUM_CH-1:0] ch_gnt,
  output logic              host_gnt,
  output logic              cpu_gnt
);
  import dma_arb_pkg::*;

  localparam int NGRP = 2;   // index 1: high group, index 0: low group

  logic [NUM_CH-1:0] eff_req;
  logic [NUM_CH-1:0] grp_req  [NGRP];
  logic [NUM_CH-1:0] grp_pick [NGRP];
  logic [NGRP-1:0]   grp_any;
  logic [NGRP-1:0]   grp_adv;
  logic              gap_ready;
  bus_owner_e        owner;
  logic [NUM_CH-1:0] dma_pick;

  assign eff_req    = ch_req & ch_en;
  assign grp_req[1] = eff_req & ch_hi;
  assign grp_req[0] = eff_req & ~ch_hi;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    dma_rr_group #(.N(NUM_CH)) u_grp (
      .clk  (clk),
      .rst  (rst),
      .req  (grp_req[g]),
      .adv  (grp_adv[g]),
      .pick (grp_pick[g]),
      .any  (grp_any[g])
    );
  end

  dma_gap_timer #(.GAP(GAP)) u_gap (
    .clk   (clk),
    .rst   (rst),
    .fire  (owner == OWN_DMA),
    .ready (gap_ready)
  );

  // outer chain: host, then DMA (high before low), then CPU
  always_comb begin
    if (host_req)                            owner = OWN_HOST;
    else if (gap_ready && (|grp_any))        owner = OWN_DMA;
    else if (cpu_req)                        owner = OWN_CPU;
    else                                     owner = OWN_NONE;
  end

  assign dma_pick   = grp_any[1] ? grp_pick[1] : grp_pick[0];
  assign grp_adv[1] = (owner == OWN_DMA) &&  grp_any[1];
  assign grp_adv[0] = (owner == OWN_DMA) && !grp_any[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_gnt   <= '0;
      host_gnt <= 1'b0;
      cpu_gnt  <= 1'b0;
    end else begin
      ch_gnt   <= (owner == OWN_DMA) ? dma_pick : '0;
      host_gnt <= (owner == OWN_HOST);
      cpu_gnt  <= (owner == OWN_CPU);
    end
  end

endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk #(
  parameter  int NUM_CH = 6,
  parameter  int GAP    = 4,
  localparam int SW     = $clog2(GAP + 1) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ch_req,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] ch_hi,
  input logic              host_req,
  input logic              cpu_req,
  input logic [NUM_CH-1:0] ch_gnt,
  input logic              host_gnt,
  input logic              cpu_gnt
);
  // cycles since the last visible DMA grant, saturating at GAP
  logic [SW-1:0] since_q;
  always_ff @(posedge clk) begin
    if (rst)                       since_q <= SW'(GAP);
    else if (|ch_gnt)              since_q <= SW'(1);
    else if (since_q < SW'(GAP))   since_q <= since_q + 1'b1;
  end

  p_single_owner_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({host_gnt, cpu_gnt, ch_gnt}));

  p_host_wins_r4: assert property (@(posedge clk) disable iff (rst)
    host_req |=> (host_gnt && ch_gnt == '0 && !cpu_gnt));

  p_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && |ch_gnt) |-> ((ch_gnt & ~$past(ch_en & ch_req)) == '0));

  p_high_first_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && |(ch_gnt & ~$past(ch_hi))) |->
      (($past(ch_req) & $past(ch_en) & $past(ch_hi)) == '0));

  p_spacing_r7: assert property (@(posedge clk) disable iff (rst)
    (|ch_gnt) |-> (since_q >= SW'(GAP)));

  p_cpu_fill_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cpu_req) && !$past(host_req) && ch_gnt == '0) |-> cpu_gnt);

  p_cpu_asked_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cpu_gnt) |-> $past(cpu_req));

endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.NUM_CH(NUM_CH), .GAP(GAP)) chk_i (.*);

// File: tb/dma_bus_arbiter_tb.sv
module dma_bus_arbiter_tb_top;
  localparam int NCH = 6;
  localparam int GP  = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] ch_req = '0, ch_en = '0, ch_hi = '0;
  logic           host_req = 1'b0, cpu_req = 1'b0;
  logic [NCH-1:0] ch_gnt;
  logic           host_gnt, cpu_gnt;

  always #5 clk = ~clk;

  dma_bus_arbiter #(.NUM_CH(NCH), .GAP(GP)) dut_i (
    .clk(clk), .rst(rst), .ch_req(ch_req), .ch_en(ch_en), .ch_hi(ch_hi),
    .host_req(host_req), .cpu_req(cpu_req),
    .ch_gnt(ch_gnt), .host_gnt(host_gnt), .cpu_gnt(cpu_gnt));

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // ---------------- behavioural reference model ----------------
  int             cyc = 0;
  int             last_dma = -1000;
  int             ptr [2];
  logic [NCH-1:0] exp_ch = '0;
  logic           exp_host = 1'b0, exp_cpu = 1'b0;

  always @(posedge clk) begin
    int granted;
    int gsel;
    cyc++;
    if (rst) begin
      exp_ch = '0; exp_host = 0; exp_cpu = 0;
      ptr[0] = 0; ptr[1] = 0; last_dma = -1000;
    end else begin
      exp_ch = '0; exp_host = 0; exp_cpu = 0;
      granted = -1; gsel = 0;
      if (host_req) exp_host = 1;
      else begin
        if (cyc - last_dma >= GP) begin
          for (int g = 1; g >= 0; g--) begin
            for (int k = 0; k < NCH; k++) begin
              int c;
              c = (ptr[g] + k) % NCH;
              if (granted < 0 && ch_req[c] && ch_en[c] && (ch_hi[c] == g[0])) begin
                granted = c; gsel = g;
              end
            end
          end
        end
        if (granted >= 0) begin
          exp_ch[granted] = 1'b1;
          ptr[gsel] = (granted + 1) % NCH;
          last_dma = cyc;
        end else if (cpu_req) exp_cpu = 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  string  tag = "R1";
  int     seq_idx [$];
  int     seq_cyc [$];
  int     hi_dis_grants;

  // one cycle: compare model at negedge, then drive the next inputs
  task automatic step();
    @(negedge clk);
    check({tag, " model"}, {host_gnt, cpu_gnt, 24'd0, ch_gnt}, {exp_host, exp_cpu, 24'd0, exp_ch});
    if (|ch_gnt) begin
      for (int i = 0; i < NCH; i++) if (ch_gnt[i]) begin seq_idx.push_back(i); seq_cyc.push_back(cyc); end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset holds all grants low
    check("R1 reset grants", {host_gnt, cpu_gnt, ch_gnt}, '0);
    ch_req = '1; ch_en = '1; cpu_req = 1;
    @(negedge clk);
    check("R1 grants during reset with requests", {host_gnt, cpu_gnt, ch_gnt}, '0);
    ch_req = '0; ch_en = '0; cpu_req = 0;
    rst = 0;
    step();
    check("R1 first cycle after reset", {host_gnt, cpu_gnt, ch_gnt}, '0);

    // R8: CPU alone owns the bus
    tag = "R8"; cpu_req = 1;
    step(); step();
    check("R8 cpu alone", {28'd0, cpu_gnt}, 1);
    for (int i = 0; i < 4; i++) step();

    // R4: host wins over every channel and the CPU
    tag = "R4"; host_req = 1; ch_req = '1; ch_en = '1; ch_hi = 6'b010101;
    step(); step();
    check("R4 host grant", {host_gnt, cpu_gnt, ch_gnt}, {1'b1, 1'b0, 6'b0});
    for (int i = 0; i < 5; i++) step();
    host_req = 0;

    // R6 / R7 / R5: high group 0,2,4 rotates, low group starved
    tag = "R6 R7 R5"; seq_idx.delete(); seq_cyc.delete();
    for (int i = 0; i < 26; i++) step();
    check("R6 first high grant", seq_idx.size() >= 3 ? seq_idx[0] : -1, 0);
    check("R6 second high grant", seq_idx.size() >= 3 ? seq_idx[1] : -1, 2);
    check("R6 third high grant", seq_idx.size() >= 3 ? seq_idx[2] : -1, 4);
    check("R6 wrap to channel 0", seq_idx.size() >= 4 ? seq_idx[3] : -1, 0);
    check("R7 spacing 1-2", seq_idx.size() >= 3 ? seq_cyc[1] - seq_cyc[0] : -1, GP);
    check("R7 spacing 2-3", seq_idx.size() >= 3 ? seq_cyc[2] - seq_cyc[1] : -1, GP);
    begin
      int lows = 0;
      foreach (seq_idx[j]) if (seq_idx[j] % 2 == 1) lows++;
      check("R5 low group starved", lows, 0);
    end

    // R5 / R6: only low channels ask; low position still at 0
    tag = "R5 R6"; ch_req = 6'b101010; seq_idx.delete(); seq_cyc.delete();
    for (int i = 0; i < 14; i++) step();
    check("R5 low served when high idle", seq_idx.size() >= 3 ? seq_idx[0] : -1, 1);
    check("R6 low rotation", seq_idx.size() >= 3 ? seq_idx[1] * 10 + seq_idx[2] : -1, 35);

    // R2: disabled channels never granted
    tag = "R2"; ch_req = '1; ch_en = 6'b000011; seq_idx.delete(); seq_cyc.delete();
    for (int i = 0; i < 30; i++) step();
    hi_dis_grants = 0;
    foreach (seq_idx[j]) if (seq_idx[j] >= 2) hi_dis_grants++;
    check("R2 disabled channels", hi_dis_grants, 0);
    check("R2 enabled channels served", seq_idx.size() > 4, 1);

    // R3 R5 R7 R8 random traffic against the model
    tag = "R3 R5 R7 R8 random";
    for (int i = 0; i < 3000; i++) begin
      step();
      ch_req   = NCH'($urandom);
      ch_en    = NCH'($urandom) | NCH'($urandom);
      if (i % 50 == 0) ch_hi = NCH'($urandom);
      host_req = ($urandom % 8) == 0;
      cpu_req  = ($urandom % 2) == 0;
      check("R3 single owner", $countones({host_gnt, cpu_gnt, ch_gnt}) <= 1, 1);
    end
    step();

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule